// File: doc/BRIEF.md
# Up-Down PWM Channel with Zero-Aligned Force

This block is one channel of a centre-aligned PWM generator. A time-base counter ramps from zero up to an active period and back down to zero. A compare value is matched against the counter on both slopes, and each match toggles an action-qualified output. At every counter-zero instant, the output is driven to a programmable level, either clear or set.

A continuous force code can pin the output low or high, or release it. In shadowed mode, the new code, the new zero action, the compare value and the period all become active together at the counter-zero event. Because they switch at the same instant, a change of modulation sector in a three-leg inverter leaves no stray edge on the output.

A master channel emits a sync pulse at counter zero. A slave channel re-phases itself on that pulse and passes it downstream, so three channels run in step. The channel also gives a conversion-start pulse at zero and another at the peak.

Top module: `updown_pwm_channel`

## Requirements
- R1: After reset the counter counts up by one per clock. It reaches the active period (at least 2, reset value `RST_PERIOD`, default 4800), reverses, and counts down by one to zero. From zero it steps to 1 and counts up again.
- R2: A period write lands in a shadow copy. The active period takes the shadow value only at the clock edge that ends a cycle in which the counter is zero.
- R3: A compare write lands in a shadow copy. The active compare takes the shadow value only at the clock edge that ends a counter-zero cycle.
- R4: In a cycle where the counter equals the active compare, the qualified output toggles at the next edge, on either slope. A compare of 0 or equal to the active period never toggles.
- R5: In a counter-zero cycle, the qualified output is loaded at the next edge with the zero-action shadow bit (0 = clear, 1 = set). This takes priority over any compare match.
- R6: The active force code decides `pwmOut`: 1 forces 0, 2 forces 1, and 0 or 3 pass the qualified output through.
- R7: With `forceShadowEn` = 1, the active force code takes the shadow code at the edge ending a counter-zero cycle, and at no other time. With `forceShadowEn` = 0, a force write becomes active at the next edge.
- R8: A write to any shadow register during a counter-zero cycle does not reach the active copy at that zero event. It waits for the next zero event.
- R9: With `isMaster` = 1, `syncOut` is high exactly in counter-zero cycles and `syncIn` is ignored. With `isMaster` = 0, `syncOut` follows `syncIn`. A high `syncIn` makes the next counter value 1, counting up.
- R10: `socZero` is high in every cycle where the counter is zero. `socPeak` is high in every cycle where the counter equals the active period while counting up.
- R11: During and right after reset, the counter is 0, `pwmOut` is 0, the force code is none, the zero action is clear and both compare copies are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| isMaster | input | 1 | 1 = master time base, 0 = slave that follows syncIn |
| syncIn | input | 1 | Sync pulse from the upstream channel |
| syncOut | output | 1 | Sync pulse to the downstream channel |
| prdWr | input | 1 | Period shadow write strobe |
| prdIn | input | CNT_W | Period write data |
| cmpWr | input | 1 | Compare shadow write strobe |
| cmpIn | input | CNT_W | Compare write data |
| forceShadowEn | input | 1 | 1 = force applies at counter zero, 0 = immediately |
| forceWr | input | 1 | Force code write strobe |
| forceIn | input | 2 | Force code: 0 none, 1 low, 2 high, 3 none |
| zeroActWr | input | 1 | Zero-action shadow write strobe |
| zeroActIn | input | 1 | Zero action: 0 clear, 1 set |
| pwmOut | output | 1 | Channel output |
| cnt | output | CNT_W | Time-base counter value |
| socZero | output | 1 | Conversion start at counter zero |
| socPeak | output | 1 | Conversion start at counter peak |

## Verification
The shadow copies are internal, so a wrong load instant shows up at the ports. A period loaded at the wrong time moves the peak and `socPeak` within one ramp. A compare loaded at the wrong time moves a `pwmOut` edge within the same half period. A force or zero action applied off the zero event gives an edge on `pwmOut` in the very next cycle, before the zero-aligned point. The bench runs a cycle-accurate reference built from the requirements and compares counter, output, sync and conversion pulses in every cycle. Most defects therefore show within one PWM period of the stimulus that exposes them.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  // Strobes from time-base control to the action-qualifier datapath
  typedef struct packed {
    logic zeroHit;  // counter is zero this cycle
    logic cmpHit;   // qualified compare match this cycle
  } pwmStrobe_t;

  typedef enum logic [1:0] {
    FORCE_NONE = 2'd0,
    FORCE_LOW  = 2'd1,
    FORCE_HIGH = 2'd2,
    FORCE_RSVD = 2'd3
  } forceCode_t;

endpackage

// File: rtl/pwm_tb_ctrl.sv
module pwm_tb_ctrl
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RST_PERIOD = 4800
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             isMaster,
  input  logic             syncIn,
  input  logic             prdWr,
  input  logic [CNT_W-1:0] prdIn,
  input  logic             cmpWr,
  input  logic [CNT_W-1:0] cmpIn,
  output pwmStrobe_t       strobe,
  output logic [CNT_W-1:0] cnt,
  output logic             socZero,
  output logic             socPeak,
  output logic             syncOut
);

  localparam logic [CNT_W-1:0] PRD_INIT = CNT_W'(RST_PERIOD);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] prdSh, prdAct, cmpSh, cmpAct;
  logic             countUp;
  logic             zeroEv, peakEv, slaveSync;

  assign zeroEv    = (cnt == '0);
  assign peakEv    = countUp && (cnt == prdAct);
  assign slaveSync = !isMaster && syncIn;

  assign strobe.zeroHit = zeroEv;
  assign strobe.cmpHit  = !zeroEv && (cnt == cmpAct) &&
                          (cmpAct != '0) && (cmpAct != prdAct);

  assign socZero = zeroEv;
  assign socPeak = peakEv;
  assign syncOut = isMaster ? zeroEv : syncIn;

  // Time-base counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      countUp <= 1'b1;
    end else if (slaveSync) begin
      cnt     <= ONE;
      countUp <= 1'b1;
    end else if (zeroEv) begin
      cnt     <= ONE;
      countUp <= 1'b1;
    end else if (peakEv) begin
      cnt     <= cnt - ONE;
      countUp <= 1'b0;
    end else if (countUp) begin
      cnt <= cnt + ONE;
    end else begin
      cnt <= cnt - ONE;
    end
  end

  // Shadow and active copies; old shadow moves to active at zero
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prdSh  <= PRD_INIT;
      prdAct <= PRD_INIT;
      cmpSh  <= '0;
      cmpAct <= '0;
    end else begin
      if (prdWr) prdSh <= prdIn;
      if (cmpWr) cmpSh <= cmpIn;
      if (zeroEv) begin
        prdAct <= prdSh;
        cmpAct <= cmpSh;
      end
    end
  end

  AST_ZERO_TURNS_UP: assert property (@(posedge clk) disable iff (!rstN)
    (zeroEv && !slaveSync) |=> (cnt == ONE)); // R1
  AST_PEAK_TURNS_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (peakEv && !slaveSync) |=> (cnt == $past(cnt) - ONE)); // R1
  AST_PRD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !zeroEv |=> $stable(prdAct)); // R2
  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !zeroEv |=> $stable(cmpAct)); // R3
  AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    slaveSync |=> (cnt == ONE) && countUp); // R9

endmodule

// File: rtl/pwm_aq_path.sv
module pwm_aq_path
  import pwm_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pwmStrobe_t strobe,
  input  logic       forceShadowEn,
  input  logic       forceWr,
  input  logic [1:0] forceIn,
  input  logic       zeroActWr,
  input  logic       zeroActIn,
  output logic       pwmOut
);

  forceCode_t forceSh, forceAct;
  logic       zeroActSh;
  logic       aqOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      forceSh   <= FORCE_NONE;
      forceAct  <= FORCE_NONE;
      zeroActSh <= 1'b0;
      aqOut     <= 1'b0;
    end else begin
      if (forceWr)   forceSh   <= forceCode_t'(forceIn);
      if (zeroActWr) zeroActSh <= zeroActIn;
      if (forceShadowEn) begin
        if (strobe.zeroHit) forceAct <= forceSh;
      end else if (forceWr) begin
        forceAct <= forceCode_t'(forceIn);
      end
      if (strobe.zeroHit)     aqOut <= zeroActSh;
      else if (strobe.cmpHit) aqOut <= ~aqOut;
    end
  end

  always_comb begin
    unique case (forceAct)
      FORCE_LOW:  pwmOut = 1'b0;
      FORCE_HIGH: pwmOut = 1'b1;
      default:    pwmOut = aqOut;
    endcase
  end

  AST_ZERO_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zeroHit |=> (aqOut == $past(zeroActSh))); // R5
  AST_CMP_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmpHit && !strobe.zeroHit) |=> (aqOut != $past(aqOut))); // R4
  AST_FORCE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (forceShadowEn && !strobe.zeroHit) |=> $stable(forceAct)); // R7

endmodule

// File: rtl/updown_pwm_channel.sv
module updown_pwm_channel
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RST_PERIOD = 4800
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             isMaster,
  input  logic             syncIn,
  output logic             syncOut,
  input  logic             prdWr,
  input  logic [CNT_W-1:0] prdIn,
  input  logic             cmpWr,
  input  logic [CNT_W-1:0] cmpIn,
  input  logic             forceShadowEn,
  input  logic             forceWr,
  input  logic [1:0]       forceIn,
  input  logic             zeroActWr,
  input  logic             zeroActIn,
  output logic             pwmOut,
  output logic [CNT_W-1:0] cnt,
  output logic             socZero,
  output logic             socPeak
);

  pwmStrobe_t strobe;

  pwm_tb_ctrl #(.CNT_W(CNT_W), .RST_PERIOD(RST_PERIOD)) i_ctrl (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .syncIn(syncIn),
    .prdWr(prdWr), .prdIn(prdIn), .cmpWr(cmpWr), .cmpIn(cmpIn),
    .strobe(strobe), .cnt(cnt), .socZero(socZero), .socPeak(socPeak),
    .syncOut(syncOut)
  );

  pwm_aq_path i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .forceShadowEn(forceShadowEn), .forceWr(forceWr), .forceIn(forceIn),
    .zeroActWr(zeroActWr), .zeroActIn(zeroActIn), .pwmOut(pwmOut)
  );

endmodule

// File: tb/test_updown_pwm_channel.sv
`timescale 1ns/1ps
module test_updown_pwm_channel;

  localparam int CW = 16;
  localparam int RP = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic isMaster = 1'b1, syncIn = 1'b0;
  logic prdWr = 1'b0, cmpWr = 1'b0, forceWr = 1'b0, zeroActWr = 1'b0;
  logic [CW-1:0] prdIn = '0, cmpIn = '0;
  logic [1:0] forceIn = 2'd0;
  logic forceShadowEn = 1'b1, zeroActIn = 1'b0;
  logic syncOut, pwmOut, socZero, socPeak;
  logic [CW-1:0] cnt;

  int vectors = 0, errors = 0;
  bit done = 1'b0;

  // reference state
  logic [CW-1:0] mCnt, mPrd, mPrdSh, mCmp, mCmpSh;
  logic mUp, mAq, mZaSh;
  logic [1:0] mForce, mForceSh;

  always #5 clk = ~clk;

  updown_pwm_channel #(.CNT_W(CW), .RST_PERIOD(RP)) i_updown_pwm_channel (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .syncIn(syncIn),
    .syncOut(syncOut), .prdWr(prdWr), .prdIn(prdIn), .cmpWr(cmpWr),
    .cmpIn(cmpIn), .forceShadowEn(forceShadowEn), .forceWr(forceWr),
    .forceIn(forceIn), .zeroActWr(zeroActWr), .zeroActIn(zeroActIn),
    .pwmOut(pwmOut), .cnt(cnt), .socZero(socZero), .socPeak(socPeak)
  );

  function automatic logic expPwm(logic [1:0] f, logic aq);
    return (f == 2'd1) ? 1'b0 : (f == 2'd2) ? 1'b1 : aq;
  endfunction

  task automatic check(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mCnt = '0; mUp = 1'b1; mPrd = CW'(RP); mPrdSh = CW'(RP);
    mCmp = '0; mCmpSh = '0; mAq = 1'b0; mZaSh = 1'b0;
    mForce = 2'd0; mForceSh = 2'd0;
  endtask

  // advance the reference by one clock using the inputs now applied
  task automatic modelStep();
    logic zeroE, hit;
    zeroE = (mCnt == '0);
    hit   = !zeroE && (mCnt == mCmp) && (mCmp != mPrd);
    if (zeroE) mAq = mZaSh; else if (hit) mAq = ~mAq;
    if (forceShadowEn) begin
      if (zeroE) mForce = mForceSh;
    end else if (forceWr) mForce = forceIn;
    if (forceWr) mForceSh = forceIn;
    if (zeroActWr) mZaSh = zeroActIn;
    if (!isMaster && syncIn) begin mCnt = 1; mUp = 1'b1; end
    else if (zeroE) begin mCnt = 1; mUp = 1'b1; end
    else if (mUp && mCnt == mPrd) begin mCnt = mCnt - 1; mUp = 1'b0; end
    else if (mUp) mCnt = mCnt + 1;
    else mCnt = mCnt - 1;
    if (zeroE) begin mPrd = mPrdSh; mCmp = mCmpSh; end
    if (prdWr) mPrdSh = prdIn;
    if (cmpWr) mCmpSh = cmpIn;
  endtask

  task automatic compareAll();
    check("R1 R2 R9 cnt", cnt, mCnt);
    check("R3 R4 R5 R6 R7 R8 pwmOut", CW'(pwmOut), CW'(expPwm(mForce, mAq)));
    check("R10 socZero", CW'(socZero), CW'(mCnt == '0));
    check("R10 R2 socPeak", CW'(socPeak), CW'(mUp && mCnt == mPrd));
    check("R9 syncOut", CW'(syncOut), CW'(isMaster ? (mCnt == '0) : syncIn));
  endtask

  task automatic clearWr();
    prdWr = 0; cmpWr = 0; forceWr = 0; zeroActWr = 0; syncIn = 0;
  endtask

  task automatic cycle();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll();
    clearWr();
  endtask

  task automatic runTo(logic [CW-1:0] target);
    int guard = 0;
    while (mCnt != target && guard < 200) begin cycle(); guard++; end
  endtask

  task automatic randStep(bit slaveMode);
    logic [CW-1:0] cmax;
    cmax = mPrdSh + 2;
    if ($urandom_range(39) == 0) begin prdWr = 1; prdIn = CW'($urandom_range(30, 4)); end
    if ($urandom_range(7) == 0)  begin cmpWr = 1; cmpIn = CW'($urandom_range(int'(cmax))); end
    if ($urandom_range(19) == 0) begin forceWr = 1; forceIn = 2'($urandom_range(3)); end
    if ($urandom_range(19) == 0) begin zeroActWr = 1; zeroActIn = 1'($urandom_range(1)); end
    if (slaveMode && $urandom_range(49) == 0) syncIn = 1;
    cycle();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state while held
    check("R11 cnt", cnt, '0);
    check("R11 pwmOut", CW'(pwmOut), '0);
    check("R11 socPeak", CW'(socPeak), '0);
    rstN = 1'b1;

    // R1 R10: first ramp at reset period
    repeat (2 * RP + 3) cycle();

    // R3 R4: compare shadowed, mid ramp toggles on both slopes
    runTo(CW'(3)); cmpWr = 1; cmpIn = CW'(5); cycle();
    repeat (3 * RP) cycle();

    // R8: writes in the zero cycle wait one more period
    runTo('0); cmpWr = 1; cmpIn = CW'(8); prdWr = 1; prdIn = CW'(9);
    forceWr = 1; forceIn = 2'd2; zeroActWr = 1; zeroActIn = 1'b1; cycle();
    repeat (2 * RP + 4) cycle();

    // R6 R7: shadowed force low, then release; R4: compare 0 and period
    runTo(CW'(4)); forceWr = 1; forceIn = 2'd1; cycle();
    repeat (30) cycle();
    forceWr = 1; forceIn = 2'd3; cmpWr = 1; cmpIn = '0; cycle();
    repeat (30) cycle();
    cmpWr = 1; cmpIn = CW'(9); cycle();
    repeat (40) cycle();

    // R7: immediate force mode
    forceShadowEn = 0;
    runTo(CW'(5)); forceWr = 1; forceIn = 2'd2; cycle();
    repeat (3) cycle();
    forceWr = 1; forceIn = 2'd0; cycle();
    repeat (800) randStep(1'b0);

    // master, shadowed: random
    forceShadowEn = 1;
    repeat (4000) randStep(1'b0);

    // R9: slave following sync, directed then random
    isMaster = 0;
    runTo(CW'(6)); syncIn = 1; cycle();
    repeat (5) cycle();
    repeat (1500) randStep(1'b1);
    isMaster = 1;
    syncIn = 1; cycle(); // R9: master ignores syncIn
    repeat (20) cycle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule